// File: doc/BRIEF.md
# Quad DAC Double-Buffered Load Controller

This block is the digital register side of a four-channel, 14-bit converter. A host writes words over a parallel bus framed by an active-low select and an active-low write strobe. Each channel has two stages: an input register that takes bus writes, and a DAC latch that holds the code presented to the converter. A level-sensitive load control decides when codes move from the first stage to the second. The controller runs on one system clock. Every bus and control input passes through a two-flop synchronizer, and strobe edges are found on the synchronized copies.

A word can be written in one step, or in two steps as a low byte followed by a high 6-bit field. An address bit broadcasts one write to all four channels. An active-low clear switches every channel's output-select flag to its ground-sense source. Channels 0 and 1 share ground source A, and channels 2 and 3 share source B. The flags stay on ground until a later falling edge of the load control. The DAC latches keep their contents through a clear.

Top module: `dacq_load_ctrl`

## Requirements
- R1: A write commits on the clock after the synchronized select/write pair stops being jointly low. A write strobe pulsed while select is high stores nothing.
- R2: With `byte_hi` = 1, all 14 bits of `bus_data` are stored, with bit 13 as the MSB.
- R3: With `byte_hi` = 0, `bus_data[5:0]` goes to bits 13:8 of the input register, and bits 7:0 keep their value.
- R4: With `bus_addr[2]` = 0, only channel `bus_addr[1:0]` is written. The other channels keep their values.
- R5: With `bus_addr[2]` = 1, a single write stores the same word in all four input registers.
- R6: While `load_n` is high, writes do not change any DAC latch.
- R7: A falling edge of `load_n` while `clear_n` is high copies all four input registers into their DAC latches in the same cycle.
- R8: A write committed while `load_n` is low and `clear_n` is high also updates the latch of each addressed channel.
- R9: While `clear_n` is low, all `gnd_sel` bits are 1 and `load_n` is ignored. The DAC latches do not change, even when writes arrive with `load_n` low.
- R10: After `clear_n` returns high, `gnd_sel` stays all ones until the next falling edge of `load_n`. That edge clears every bit of `gnd_sel` and transfers the input registers to the latches.
- R11: After reset, all input registers and latches are zero and `gnd_sel` is 4'b1111.
- R12: When a write commit and a load falling edge fall in the same cycle, all latches are loaded. Each addressed channel takes the newly written word, and the other channels take their input registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low bus select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe; its release commits the write |
| byte_hi | input | 1 | 1: store the whole word; 0: shift the low 6 bits into the upper field |
| bus_addr | input | 3 | [1:0] channel index, [2] broadcast to all channels |
| bus_data | input | 14 | Write data |
| load_n | input | 1 | Active-low, level-sensitive load control |
| clear_n | input | 1 | Active-low clear to ground-sense sources |
| dac_code | output | 56 | Four DAC latches; channel c is bits [14c+13:14c] |
| gnd_sel | output | 4 | Per channel: 1 = ground-sense source, 0 = latch value |

## Verification
A write commit and a load falling edge can land in the same clock cycle, because both pass through synchronizers of equal depth. The bench creates this case by releasing the write strobe and pulling `load_n` low on the same clock edge. It then checks that the addressed channel shows the new word while every other channel shows its earlier input-register value. A second overlap involves clear and load. The bench drives load low while clear is still asserted, then releases clear, and expects the flags to stay on ground until a fresh load edge arrives.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int DACQ_CODE_W = 14;
  localparam int DACQ_N_CH   = 4;
  localparam int DACQ_LO_W   = 8;
  localparam int DACQ_SYNC_STAGES = 2;
endpackage

// File: rtl/dacq_sync.sv
module dacq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacq_bus_decode.sv
module dacq_bus_decode #(
  parameter int N_CH = 4,
  localparam int AW = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            wr_n,
  input  logic [AW:0]     addr,
  output logic            commit,
  output logic [N_CH-1:0] ch_en
);
  logic act, act_q;

  assign act = ~sel_n & ~wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign commit = act_q & ~act;

  for (genvar c = 0; c < N_CH; c++) begin : g_en
    assign ch_en[c] = commit & (addr[AW] | (addr[AW-1:0] == AW'(c)));
  end

  AST_SINGLE_CH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !addr[AW]) |-> $onehot(ch_en)); // R4
  AST_BROADCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr[AW]) |-> (&ch_en)); // R5
endmodule

// File: rtl/dacq_out_ctl.sv
module dacq_out_ctl #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_n,
  input  logic            clr_n,
  output logic            xfer_all,
  output logic            imm_load,
  output logic [N_CH-1:0] gnd_sel
);
  logic load_q;

  always_ff @(posedge clk) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= load_n;
  end

  assign xfer_all = clr_n & load_q & ~load_n;
  assign imm_load = clr_n & ~load_n;

  always_ff @(posedge clk) begin
    if (!rst_n)        gnd_sel <= '1;
    else if (!clr_n)   gnd_sel <= '1;
    else if (xfer_all) gnd_sel <= '0;
  end

  AST_CLEAR_FORCES_GND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (&gnd_sel)); // R9
  AST_GND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gnd_sel) && !xfer_all) |=> (&gnd_sel)); // R10
  AST_NO_LOAD_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !(xfer_all || imm_load)); // R9
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan #(
  parameter int W = 14,
  parameter int LO_W = 8,
  localparam int HI_W = W - LO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         byte_hi,
  input  logic [W-1:0] data,
  input  logic         imm_load,
  input  logic         xfer_all,
  output logic [W-1:0] latch
);
  logic [W-1:0] in_reg, new_val;

  assign new_val = byte_hi ? data : {data[HI_W-1:0], in_reg[LO_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg <= '0;
      latch  <= '0;
    end else begin
      if (wr_en) in_reg <= new_val;
      if (wr_en && (imm_load || xfer_all)) latch <= new_val;
      else if (xfer_all)                   latch <= in_reg;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_all && !(wr_en && imm_load)) |=> $stable(latch)); // R6
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_all && !wr_en) |=> (latch == $past(in_reg))); // R7
  AST_IMM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && imm_load) |=> (latch == in_reg)); // R8
endmodule

// File: rtl/dacq_load_ctrl.sv
module dacq_load_ctrl
  import dacq_pkg::*;
#(
  parameter int CODE_W = DACQ_CODE_W,
  parameter int N_CH = DACQ_N_CH,
  parameter int LO_W = DACQ_LO_W,
  parameter int SYNC_STAGES = DACQ_SYNC_STAGES,
  localparam int AW = $clog2(N_CH),
  localparam int SW = 5 + AW + 1 + CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n,
  input  logic                   wr_n,
  input  logic                   byte_hi,
  input  logic [AW:0]            bus_addr,
  input  logic [CODE_W-1:0]      bus_data,
  input  logic                   load_n,
  input  logic                   clear_n,
  output logic [N_CH*CODE_W-1:0] dac_code,
  output logic [N_CH-1:0]        gnd_sel
);
  localparam logic [SW-1:0] SYNC_RST = {5'b11111, {(AW+1+CODE_W){1'b0}}};

  logic [SW-1:0]     raw, syn;
  logic              s_sel_n, s_wr_n, s_load_n, s_clr_n, s_byte_hi;
  logic [AW:0]       s_addr;
  logic [CODE_W-1:0] s_data;
  logic              commit, xfer_all, imm_load;
  logic [N_CH-1:0]   ch_en;

  assign raw = {sel_n, wr_n, load_n, clear_n, byte_hi, bus_addr, bus_data};

  dacq_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign {s_sel_n, s_wr_n, s_load_n, s_clr_n, s_byte_hi, s_addr, s_data} = syn;

  dacq_bus_decode #(.N_CH(N_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(s_sel_n), .wr_n(s_wr_n), .addr(s_addr),
    .commit(commit), .ch_en(ch_en));

  dacq_out_ctl #(.N_CH(N_CH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load_n(s_load_n), .clr_n(s_clr_n),
    .xfer_all(xfer_all), .imm_load(imm_load), .gnd_sel(gnd_sel));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dacq_chan #(.W(CODE_W), .LO_W(LO_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(ch_en[c]), .byte_hi(s_byte_hi),
      .data(s_data), .imm_load(imm_load), .xfer_all(xfer_all),
      .latch(dac_code[c*CODE_W +: CODE_W]));
  end

  AST_CLEAR_FREEZES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !s_clr_n |=> $stable(dac_code)); // R9
  AST_GND_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gnd_sel[0]) |-> $past(s_clr_n && !s_load_n)); // R10
endmodule

// File: tb/test_dacq_load_ctrl.sv
module test_dacq_load_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, wr_n = 1, byte_hi = 1, load_n = 1, clear_n = 1;
  logic [2:0] bus_addr = '0;
  logic [W-1:0] bus_data = '0;
  logic [4*W-1:0] dac_code;
  logic [3:0] gnd_sel;
  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacq_load_ctrl i_dacq_load_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .byte_hi(byte_hi),
    .bus_addr(bus_addr), .bus_data(bus_data), .load_n(load_n),
    .clear_n(clear_n), .dac_code(dac_code), .gnd_sel(gnd_sel));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_code(input string req, input int ch, input logic [W-1:0] exp);
    n_tests++;
    if (dac_code[ch*W +: W] !== exp) begin
      n_fail++;
      $display("FAIL %s ch%0d code: actual %h expected %h", req, ch, dac_code[ch*W +: W], exp);
    end
  endtask

  task automatic chk_gnd(input string req, input logic [3:0] exp);
    n_tests++;
    if (gnd_sel !== exp) begin
      n_fail++;
      $display("FAIL %s gnd_sel: actual %b expected %b", req, gnd_sel, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [W-1:0] e0, e1, e2, e3);
    chk_code(req, 0, e0); chk_code(req, 1, e1);
    chk_code(req, 2, e2); chk_code(req, 3, e3);
  endtask

  // bus write; with_load pulls load_n low on the edge that releases the strobe
  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d, input logic hi,
                        input logic cs, input logic with_load);
    @(negedge clk);
    bus_addr = a; bus_data = d; byte_hi = hi; sel_n = ~cs;
    idle(2); wr_n = 0;
    idle(3); wr_n = 1;
    if (with_load) load_n = 0;
    idle(3); sel_n = 1;
    idle(6);
  endtask

  task automatic load_pulse();
    @(negedge clk); load_n = 0; idle(6); load_n = 1; idle(6);
  endtask

  task automatic t_reset();
    chk_all("R11", 0, 0, 0, 0);
    chk_gnd("R11", 4'b1111);
  endtask

  task automatic t_full_word();
    bus_wr(3'b001, 14'h2A5C, 1, 1, 0);
    chk_all("R6", 0, 0, 0, 0);
    bus_wr(3'b001, 14'h1111, 1, 0, 0);   // select high: ignored (R1)
    load_pulse();
    chk_all("R1 R2 R4 R7", 0, 14'h2A5C, 0, 0);
    chk_gnd("R10", 4'b0000);
  endtask

  task automatic t_byte();
    bus_wr(3'b010, 14'h00A7, 1, 1, 0);
    bus_wr(3'b010, 14'h0035, 0, 1, 0);
    chk_code("R6", 2, 0);
    load_pulse();
    chk_all("R3", 0, 14'h2A5C, 14'h35A7, 0);
  endtask

  task automatic t_broadcast();
    bus_wr(3'b100, 14'h0F0F, 1, 1, 0);
    load_pulse();
    chk_all("R5", 14'h0F0F, 14'h0F0F, 14'h0F0F, 14'h0F0F);
  endtask

  task automatic t_immediate();
    @(negedge clk); load_n = 0; idle(6);
    bus_wr(3'b011, 14'h3FFF, 1, 1, 0);
    chk_all("R8", 14'h0F0F, 14'h0F0F, 14'h0F0F, 14'h3FFF);
    load_n = 1; idle(6);
  endtask

  task automatic t_clear();
    @(negedge clk); clear_n = 0; idle(6);
    chk_gnd("R9", 4'b1111);
    load_n = 0; idle(6);
    bus_wr(3'b000, 14'h1234, 1, 1, 0);
    chk_all("R9", 14'h0F0F, 14'h0F0F, 14'h0F0F, 14'h3FFF);
    load_n = 1; idle(6);
    clear_n = 1; idle(6);
    chk_gnd("R10", 4'b1111);
    load_n = 0; idle(6);
    chk_gnd("R10", 4'b0000);
    chk_all("R10", 14'h1234, 14'h0F0F, 14'h0F0F, 14'h3FFF);
    load_n = 1; idle(6);
  endtask

  task automatic t_collision();
    bus_wr(3'b001, 14'h0111, 1, 1, 0);
    chk_code("R6", 1, 14'h0F0F);
    bus_wr(3'b010, 14'h0222, 1, 1, 1);
    chk_all("R12", 14'h1234, 14'h0111, 14'h0222, 14'h3FFF);
    load_n = 1; idle(6);
  endtask

  initial begin
    idle(4); rst_n = 1; idle(4);
    t_reset();
    t_full_word();
    t_byte();
    t_broadcast();
    t_immediate();
    t_clear();
    t_collision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule